// File: doc/BRIEF.md
# Second-Stage Address Translation Walker

This block turns an intermediate physical address (IPA) into an output address. It walks a tree of 64-bit descriptors in memory and reads one descriptor per level through a request/response read port. A walk starts when the caller hands over an IPA and a read/write flag. The configuration is sampled at that moment: granule size, input-size field, effective output size, starting level, table base and a switch that turns off access-flag faults. The walk ends with a single result beat. The beat carries either the translated address, the block mask, the leaf level and the two permission bits, or a fault code together with the IPA that faulted.

The first level may use several start tables placed side by side (concatenated). The IPA bits above the stride of the start level choose which table is used. Descriptors are not cached, and the access flag is never written back. The walker keeps one walk in flight.

Top module: `s2_walker`

## Requirements
- R1: `start_ready` is high only while the walker is idle. A walk is accepted on a clock edge where `start_valid` and `start_ready` are both high. IPA, write flag and every `cfg_*` input are captured on that edge, and `start_ready` is low on the following cycle.
- R2: Let the input size be 64 minus `cfg_tsz`. If the accepted IPA is at or above 2 to the power of the input size, the walk ends with a translation fault (code 0) at the start level, and no memory read is issued.
- R3: Granule select 0 means 4 KiB, 1 means 16 KiB and 2 means 64 KiB; 3 is treated as 4 KiB. The granule shift g is 12, 14 or 16, and the stride s is g-3. At level L the shift is g + s*(3-L). The table base is `cfg_base` with every bit at or above `cfg_eps` cleared and the low g bits cleared. The first read address is that base plus 8 times (IPA >> shift of the start level), so the IPA bits above the stride choose a concatenated table 2^s*8 bytes further on.
- R4: A descriptor whose bits [1:0] are 11 at a level below 3 is a table. The next read is at (descriptor bits [47:g], with the low g bits zero) plus 8 times the s-bit index taken from the IPA at the shift of the next level.
- R5: A walk ends with a translation fault (code 0) on a descriptor with bit 0 clear, on bits [1:0] = 01 at level 3, and on bits [1:0] = 01 at level 0.
- R6: A leaf (page at level 3, or block at level 1 or 2) with access flag bit 10 clear gives an access fault (code 1) unless `cfg_af_dis` is set.
- R7: The leaf permission field is bits [7:6]: bit 6 allows reads and bit 7 allows writes. A write to a leaf with bit 7 clear gives a permission fault (code 2). Reads are always allowed. The access check comes before the permission check.
- R8: If the output address is at or above 2^`cfg_eps`, the result is an address-size fault (code 3). This check comes last.
- R9: On success, the output address is the leaf address bits above the level shift combined with the IPA bits below it. The mask is 2^shift-1. Level and permission bits are also reported.
- R10: Every fault reports `res_fault`=1, the fault code, the faulting IPA in `res_fault_addr` and the level reached, with address, mask and permissions all zero.
- R11: A memory request stays valid with a stable address until `mem_req_ready` is seen. Exactly one read is made per level visited. The walker waits for `mem_rsp_valid` before it decodes.
- R12: `res_valid` is high for exactly one cycle per walk, after which the walker is idle. The result outputs keep their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gran | input | 2 | Granule select |
| cfg_tsz | input | 6 | Input-size field (input size = 64 - value) |
| cfg_eps | input | 6 | Effective output address size in bits |
| cfg_start_lvl | input | 2 | Starting level |
| cfg_base | input | ADDR_W | Start table base |
| cfg_af_dis | input | 1 | Suppress access-flag faults |
| start_valid | input | 1 | Walk request |
| start_ready | output | 1 | Walker idle, request can be taken |
| start_ipa | input | ADDR_W | IPA to translate |
| start_write | input | 1 | Access is a write |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | DESC_W | Descriptor data |
| res_valid | output | 1 | Result beat |
| res_fault | output | 1 | Walk faulted |
| res_fault_type | output | 2 | 0 translation, 1 access, 2 permission, 3 address size |
| res_fault_addr | output | ADDR_W | IPA that faulted |
| res_oa | output | ADDR_W | Output address |
| res_mask | output | ADDR_W | Block/page offset mask |
| res_level | output | 2 | Level where the walk ended |
| res_perm | output | 2 | Permission bits {write, read} |

## Verification
The checker assumes that the memory sends exactly one response for each accepted request and never sends one while no read is outstanding. It also assumes that the caller raises `start_valid` only when it wants a walk. The bench memory model keeps to both: it schedules a single response a fixed number of cycles after each handshake, and it throttles `mem_req_ready` on a repeating pattern so that request hold is exercised. The bench's own reference walk predicts every read address in order and the final result, including the case of an out-of-range IPA where no read may appear.

// File: rtl/s2w_pkg.sv
package s2w_pkg;
  typedef enum logic [1:0] {
    FLT_XLAT   = 2'd0,
    FLT_ACCESS = 2'd1,
    FLT_PERM   = 2'd2,
    FLT_ASIZE  = 2'd3
  } s2w_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } s2w_state_e;

  // granule select to address shift
  function automatic logic [4:0] gran_shift(logic [1:0] sel);
    case (sel)
      2'd1:    return 5'd14;
      2'd2:    return 5'd16;
      default: return 5'd12;
    endcase
  endfunction

  // shift of the IPA index field at a given level
  function automatic logic [6:0] lvl_shift(logic [4:0] g, logic [1:0] lvl);
    logic [6:0] strd;
    logic [6:0] steps;
    strd  = 7'(g) - 7'd3;
    steps = 7'(2'd3 - lvl);
    return 7'(g) + 7'(strd * steps);
  endfunction
endpackage

// File: rtl/s2w_idx_addr.sv
module s2w_idx_addr #(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] ipa,
  input  logic [6:0]        shift,
  input  logic [4:0]        stride,
  input  logic              full_idx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] imask;

  always_comb begin
    imask = (ADDR_W'(1) << stride) - ADDR_W'(1);
    idx   = ipa >> shift;
    if (!full_idx) idx = idx & imask;
    addr  = tbl_base + (idx << 3);
  end
endmodule

// File: rtl/s2w_leaf_eval.sv
module s2w_leaf_eval
  import s2w_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DESC_W = 64
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [ADDR_W-1:0] ipa,
  input  logic [6:0]        shift,
  input  logic [4:0]        gshift,
  input  logic [5:0]        eps,
  input  logic              af_dis,
  input  logic              is_write,
  output logic              flt,
  output s2w_fault_e        ftype,
  output logic [ADDR_W-1:0] oa,
  output logic [ADDR_W-1:0] mask,
  output logic [1:0]        perm
);
  localparam int AF_BIT  = 10;
  localparam int AP_LO   = 6;

  logic [ADDR_W-1:0] gmask;
  logic [ADDR_W-1:0] field;

  always_comb begin
    gmask = (ADDR_W'(1) << gshift) - ADDR_W'(1);
    mask  = (ADDR_W'(1) << shift) - ADDR_W'(1);
    field = desc[ADDR_W-1:0] & ~gmask;
    oa    = (field & ~mask) | (ipa & mask);
    perm  = desc[AP_LO+1:AP_LO];
    flt   = 1'b0;
    ftype = FLT_XLAT;
    if (!desc[AF_BIT] && !af_dis) begin
      flt   = 1'b1;
      ftype = FLT_ACCESS;
    end else if (is_write && !perm[1]) begin
      flt   = 1'b1;
      ftype = FLT_PERM;
    end else if ((oa >> eps) != '0) begin
      flt   = 1'b1;
      ftype = FLT_ASIZE;
    end
  end
endmodule

// File: rtl/s2_walker.sv
module s2_walker
  import s2w_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DESC_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_gran,
  input  logic [5:0]        cfg_tsz,
  input  logic [5:0]        cfg_eps,
  input  logic [1:0]        cfg_start_lvl,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_af_dis,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_ipa,
  input  logic              start_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic              res_fault,
  output logic [1:0]        res_fault_type,
  output logic [ADDR_W-1:0] res_fault_addr,
  output logic [ADDR_W-1:0] res_oa,
  output logic [ADDR_W-1:0] res_mask,
  output logic [1:0]        res_level,
  output logic [1:0]        res_perm
);
  localparam int        IPA64_W  = 64;
  localparam logic [1:0] LAST_LVL = 2'd3;

  s2w_state_e        st_q;
  logic [ADDR_W-1:0] ipa_q;
  logic              wr_q;
  logic [4:0]        g_q;
  logic [5:0]        eps_q;
  logic              afd_q;
  logic [1:0]        lvl_q;
  logic [ADDR_W-1:0] req_addr_q;

  // start-side combinational terms
  logic [4:0]         g_in;
  logic [6:0]         insz;
  logic [IPA64_W-1:0] ipa_ext;
  logic               out_rng;
  logic [ADDR_W-1:0]  gm_in, em_in, start_tbl, start_addr;

  always_comb begin
    g_in      = gran_shift(cfg_gran);
    insz      = 7'd64 - 7'(cfg_tsz);
    ipa_ext   = IPA64_W'(start_ipa);
    out_rng   = (ipa_ext >> insz) != '0;
    gm_in     = (ADDR_W'(1) << g_in) - ADDR_W'(1);
    em_in     = (ADDR_W'(1) << cfg_eps) - ADDR_W'(1);
    start_tbl = cfg_base & em_in & ~gm_in;
  end

  s2w_idx_addr #(.ADDR_W(ADDR_W)) u_first (
    .tbl_base (start_tbl),
    .ipa      (start_ipa),
    .shift    (lvl_shift(g_in, cfg_start_lvl)),
    .stride   (g_in - 5'd3),
    .full_idx (1'b1),
    .addr     (start_addr)
  );

  // walk-side combinational terms
  logic [ADDR_W-1:0] gm_q, next_tbl, next_addr;
  logic [6:0]        cur_shift, nxt_shift;
  logic [1:0]        lvl_nxt;

  always_comb begin
    gm_q      = (ADDR_W'(1) << g_q) - ADDR_W'(1);
    next_tbl  = mem_rsp_data[ADDR_W-1:0] & ~gm_q;
    lvl_nxt   = lvl_q + 2'd1;
    cur_shift = lvl_shift(g_q, lvl_q);
    nxt_shift = lvl_shift(g_q, lvl_nxt);
  end

  s2w_idx_addr #(.ADDR_W(ADDR_W)) u_next (
    .tbl_base (next_tbl),
    .ipa      (ipa_q),
    .shift    (nxt_shift),
    .stride   (g_q - 5'd3),
    .full_idx (1'b0),
    .addr     (next_addr)
  );

  logic              lf_flt;
  s2w_fault_e        lf_type;
  logic [ADDR_W-1:0] lf_oa, lf_mask;
  logic [1:0]        lf_perm;

  s2w_leaf_eval #(.ADDR_W(ADDR_W), .DESC_W(DESC_W)) u_leaf (
    .desc     (mem_rsp_data),
    .ipa      (ipa_q),
    .shift    (cur_shift),
    .gshift   (g_q),
    .eps      (eps_q),
    .af_dis   (afd_q),
    .is_write (wr_q),
    .flt      (lf_flt),
    .ftype    (lf_type),
    .oa       (lf_oa),
    .mask     (lf_mask),
    .perm     (lf_perm)
  );

  // descriptor classification
  logic d_valid, d_table, d_bad_leaf;
  always_comb begin
    d_valid    = mem_rsp_data[0];
    d_table    = mem_rsp_data[1] && (lvl_q != LAST_LVL);
    d_bad_leaf = (lvl_q == LAST_LVL) ? !mem_rsp_data[1] : (lvl_q == 2'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      ipa_q          <= '0;
      wr_q           <= 1'b0;
      g_q            <= 5'd12;
      eps_q          <= '0;
      afd_q          <= 1'b0;
      lvl_q          <= '0;
      req_addr_q     <= '0;
      res_fault      <= 1'b0;
      res_fault_type <= '0;
      res_fault_addr <= '0;
      res_oa         <= '0;
      res_mask       <= '0;
      res_level      <= '0;
      res_perm       <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_valid) begin
            ipa_q      <= start_ipa;
            wr_q       <= start_write;
            g_q        <= g_in;
            eps_q      <= cfg_eps;
            afd_q      <= cfg_af_dis;
            lvl_q      <= cfg_start_lvl;
            req_addr_q <= start_addr;
            if (out_rng) begin
              st_q           <= ST_DONE;
              res_fault      <= 1'b1;
              res_fault_type <= FLT_XLAT;
              res_fault_addr <= start_ipa;
              res_oa         <= '0;
              res_mask       <= '0;
              res_level      <= cfg_start_lvl;
              res_perm       <= '0;
            end else begin
              st_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (d_valid && d_table) begin
              lvl_q      <= lvl_nxt;
              req_addr_q <= next_addr;
              st_q       <= ST_REQ;
            end else begin
              st_q      <= ST_DONE;
              res_level <= lvl_q;
              if (!d_valid || d_bad_leaf || lf_flt) begin
                res_fault      <= 1'b1;
                res_fault_type <= (!d_valid || d_bad_leaf) ? FLT_XLAT : lf_type;
                res_fault_addr <= ipa_q;
                res_oa         <= '0;
                res_mask       <= '0;
                res_perm       <= '0;
              end else begin
                res_fault      <= 1'b0;
                res_fault_type <= FLT_XLAT;
                res_fault_addr <= '0;
                res_oa         <= lf_oa;
                res_mask       <= lf_mask;
                res_perm       <= lf_perm;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign start_ready   = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = req_addr_q;
  assign res_valid     = (st_q == ST_DONE);
endmodule

// File: rtl/s2_walker_chk.sv
module s2_walker_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              start_valid,
  input logic              start_ready,
  input logic [ADDR_W-1:0] start_ipa,
  input logic [5:0]        cfg_eps,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              res_valid,
  input logic              res_fault,
  input logic [ADDR_W-1:0] res_fault_addr,
  input logic [ADDR_W-1:0] res_oa,
  input logic [1:0]        res_level
);
  logic [ADDR_W-1:0] ipa_cap;
  logic [5:0]        eps_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ipa_cap <= '0;
      eps_cap <= '0;
    end else if (start_valid && start_ready) begin
      ipa_cap <= start_ipa;
      eps_cap <= cfg_eps;
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r11_no_req_idle: assert property (@(posedge clk) disable iff (rst)
    start_ready |-> !mem_req_valid);

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    start_valid && start_ready |=> !start_ready);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid && start_ready);

  a_r10_fault_ipa: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_fault |-> res_fault_addr == ipa_cap);

  a_r5_no_level0_leaf: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_fault |-> res_level != 2'd0);

  a_r8_oa_in_range: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_fault |-> (res_oa >> eps_cap) == '0);
endmodule

bind s2_walker s2_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .start_valid    (start_valid),
  .start_ready    (start_ready),
  .start_ipa      (start_ipa),
  .cfg_eps        (cfg_eps),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .res_valid      (res_valid),
  .res_fault      (res_fault),
  .res_fault_addr (res_fault_addr),
  .res_oa         (res_oa),
  .res_level      (res_level)
);

// File: tb/s2_walker_tb_top.sv
`timescale 1ns/1ps
module s2_walker_tb_top;
  localparam int AW  = 48;
  localparam int DW  = 64;
  localparam int LAT = 3;
  localparam logic [63:0] AMASK = (64'd1 << AW) - 64'd1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic [1:0]    cfg_gran;
  logic [5:0]    cfg_tsz, cfg_eps;
  logic [1:0]    cfg_start_lvl;
  logic [AW-1:0] cfg_base;
  logic          cfg_af_dis;
  logic          start_valid, start_ready, start_write;
  logic [AW-1:0] start_ipa;
  logic          mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic          res_valid, res_fault;
  logic [1:0]    res_fault_type, res_level, res_perm;
  logic [AW-1:0] res_fault_addr, res_oa, res_mask;

  s2_walker #(.ADDR_W(AW), .DESC_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_gran(cfg_gran), .cfg_tsz(cfg_tsz), .cfg_eps(cfg_eps),
    .cfg_start_lvl(cfg_start_lvl), .cfg_base(cfg_base), .cfg_af_dis(cfg_af_dis),
    .start_valid(start_valid), .start_ready(start_ready), .start_ipa(start_ipa),
    .start_write(start_write), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_fault_type(res_fault_type),
    .res_fault_addr(res_fault_addr), .res_oa(res_oa), .res_mask(res_mask),
    .res_level(res_level), .res_perm(res_perm)
  );

  logic [63:0] mem [longint unsigned];
  logic [63:0] exp_q [$];
  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  // memory responder with fixed latency, throttled ready
  int  cyc = 0;
  bit  pend = 1'b0;
  int  cnt = 0;
  logic [63:0] paddr = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      pend = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data = '0;
      mem_req_ready = 1'b1;
    end else begin
      mem_req_ready = (cyc % 3) != 0;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = rd(paddr);
          pend = 1'b0;
        end
      end
      if (mem_req_valid && start_ready) check("R11", "request while idle", 1, 0);
      if (mem_req_valid && mem_req_ready) begin
        pend  = 1'b1;
        cnt   = LAT;
        paddr = 64'(mem_req_addr);
        if (exp_q.size() == 0) check("R11", "unexpected read addr", 64'(mem_req_addr), 64'hFFFF_FFFF_FFFF_FFFF);
        else check("R3/R4 R11", "read address", 64'(mem_req_addr), exp_q.pop_front());
      end
    end
  end

  // expected result
  logic        e_flt;
  logic [1:0]  e_type, e_lvl, e_perm;
  logic [63:0] e_oa, e_mask;

  task automatic ref_walk(int gsel, int tsz, int eps, int slvl, logic [63:0] base,
                          logic af_dis, logic [63:0] ipa, logic wr);
    int g, s, lvl, sh, insz;
    logic [63:0] a, d, tb, idx, oa, mk;
    g = (gsel == 1) ? 14 : (gsel == 2) ? 16 : 12;
    s = g - 3;
    insz = 64 - tsz;
    exp_q.delete();
    e_flt = 1; e_type = 0; e_oa = 0; e_mask = 0; e_perm = 0; e_lvl = 2'(slvl);
    if (insz < 64 && (ipa >> insz) != 0) return;
    tb  = base & ((64'd1 << eps) - 1) & ~((64'd1 << g) - 1);
    lvl = slvl;
    sh  = g + s * (3 - lvl);
    a   = tb + ((ipa >> sh) << 3);
    forever begin
      exp_q.push_back(a);
      d = rd(a);
      e_lvl = 2'(lvl);
      if (!d[0]) return;
      if (lvl < 3 && d[1]) begin
        tb  = d & AMASK & ~((64'd1 << g) - 1);
        lvl = lvl + 1;
        sh  = g + s * (3 - lvl);
        idx = (ipa >> sh) & ((64'd1 << s) - 1);
        a   = tb + (idx << 3);
        continue;
      end
      if (lvl == 3 && !d[1]) return;
      if (lvl == 0) return;
      mk = (64'd1 << sh) - 1;
      oa = ((d & AMASK & ~((64'd1 << g) - 1)) & ~mk) | (ipa & mk);
      if (!d[10] && !af_dis) begin e_type = 1; return; end
      if (wr && !d[7]) begin e_type = 2; return; end
      if ((oa >> eps) != 0) begin e_type = 3; return; end
      e_flt = 0; e_oa = oa; e_mask = mk; e_perm = d[7:6];
      return;
    end
  endtask

  task automatic run_walk(string req, int gsel, int tsz, int eps, int slvl,
                          logic [63:0] base, logic af_dis, logic [63:0] ipa, logic wr);
    bit got;
    ref_walk(gsel, tsz, eps, slvl, base, af_dis, ipa, wr);
    @(negedge clk);
    cfg_gran = 2'(gsel); cfg_tsz = 6'(tsz); cfg_eps = 6'(eps); cfg_start_lvl = 2'(slvl);
    cfg_base = AW'(base); cfg_af_dis = af_dis; start_ipa = AW'(ipa); start_write = wr;
    check(req, "ready before start", 64'(start_ready), 1);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    got = 0;
    for (int i = 0; i < 300; i++) begin
      if (res_valid) begin got = 1; break; end
      @(negedge clk);
    end
    check(req, "result arrived", 64'(got), 1);
    if (!got) return;
    check(req, "fault", 64'(res_fault), 64'(e_flt));
    if (e_flt) begin
      check(req, "fault type (R10)", 64'(res_fault_type), 64'(e_type));
      check(req, "fault addr (R10)", 64'(res_fault_addr), ipa);
    end
    check(req, "oa", 64'(res_oa), e_oa);
    check(req, "mask", 64'(res_mask), e_mask);
    check(req, "level", 64'(res_level), 64'(e_lvl));
    check(req, "perm", 64'(res_perm), 64'(e_perm));
    check(req, "all reads issued (R11)", 64'(exp_q.size()), 0);
    @(negedge clk);
    check("R12", "pulse ends", 64'(res_valid), 0);
    check("R12", "idle after result", 64'(start_ready), 1);
  endtask

  function automatic logic [63:0] tdesc(logic [63:0] nb);
    return nb | 64'h3;
  endfunction
  function automatic logic [63:0] ldesc(logic [63:0] oa, int ap, int af, bit page);
    return oa | (page ? 64'h3 : 64'h1) | (64'(af) << 10) | (64'(ap) << 6);
  endfunction

  localparam logic [63:0] T0 = 64'h10000, T1 = 64'h20000, T2 = 64'h30000, T3 = 64'h40000;

  function automatic logic [63:0] ipa4k(int i0, int i1, int i2, int i3, logic [63:0] off);
    return (64'(i0) << 39) | (64'(i1) << 30) | (64'(i2) << 21) | (64'(i3) << 12) | off;
  endfunction

  initial begin
    rst = 1'b1; start_valid = 1'b0; start_write = 1'b0; start_ipa = '0;
    cfg_gran = 0; cfg_tsz = 16; cfg_eps = 48; cfg_start_lvl = 0; cfg_base = '0; cfg_af_dis = 0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;

    // 4K tree
    mem[T0 + 8]      = tdesc(T1);
    mem[T0 + 16]     = ldesc(64'h80_0000_0000, 3, 1, 0);
    mem[T1 + 16]     = tdesc(T2);
    mem[T2 + 24]     = tdesc(T3);
    mem[T2 + 40]     = ldesc(64'h4000_0000, 3, 1, 0);
    mem[T3 + 32]     = ldesc(64'hABCD_E000, 3, 1, 1);
    mem[T3 + 48]     = ldesc(64'h5000_0000, 1, 1, 1);
    mem[T3 + 56]     = ldesc(64'h6000_0000, 3, 0, 1);
    mem[T3 + 72]     = ldesc(64'h7000_0000, 3, 1, 0);
    mem[T3 + 80]     = ldesc(64'h100_0000_1000, 3, 1, 1);
    // concatenated start tables, 4K, start level 1
    mem[64'h80000 + (512 + 2) * 8] = tdesc(64'h90000);
    mem[64'h90000 + 8]  = tdesc(64'hA0000);
    mem[64'hA0000 + 8]  = ldesc(64'hB000_0000, 2, 1, 1);
    // 64K tree, start level 2
    mem[64'h200000 + 24] = tdesc(64'h210000);
    mem[64'h210000 + 40] = ldesc(64'hC001_0000, 3, 1, 1);
    // 16K tree, start level 1
    mem[64'h300000]      = tdesc(64'h304000);
    mem[64'h304000 + 16] = tdesc(64'h308000);
    mem[64'h308000 + 24] = ldesc(64'hD000_4000, 1, 1, 1);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "reset ready", 64'(start_ready), 1);
    check("R12", "reset res_valid", 64'(res_valid), 0);
    check("R11", "reset req", 64'(mem_req_valid), 0);

    // R4 R9: full 4-level page walk
    run_walk("R4 R9 page", 0, 16, 48, 0, T0, 0, ipa4k(1, 2, 3, 4, 64'h123), 0);
    // R12: outputs held after result
    repeat (3) @(negedge clk);
    check("R12", "oa held", 64'(res_oa), 64'hABCD_E123);
    // R9: level-2 block, write allowed
    run_walk("R9 block", 0, 16, 48, 0, T0, 0, ipa4k(1, 2, 5, 0, 64'h1_2345), 1);
    // R7: write to read-only page, then read
    run_walk("R7 write", 0, 16, 48, 0, T0, 0, ipa4k(1, 2, 3, 6, 64'h8), 1);
    run_walk("R7 read", 0, 16, 48, 0, T0, 0, ipa4k(1, 2, 3, 6, 64'h8), 0);
    // R6: access flag
    run_walk("R6 af", 0, 16, 48, 0, T0, 0, ipa4k(1, 2, 3, 7, 64'h0), 0);
    run_walk("R6 af_dis", 0, 16, 48, 0, T0, 1, ipa4k(1, 2, 3, 7, 64'h0), 1);
    // R5: invalid, level-3 block, level-0 block
    run_walk("R5 invalid", 0, 16, 48, 0, T0, 0, ipa4k(1, 2, 3, 8, 64'h0), 0);
    run_walk("R5 l3 block", 0, 16, 48, 0, T0, 0, ipa4k(1, 2, 3, 9, 64'h0), 0);
    run_walk("R5 l0 block", 0, 16, 48, 0, T0, 0, ipa4k(2, 0, 0, 0, 64'h0), 0);
    // R2: out of range, no read
    run_walk("R2 range", 0, 20, 48, 0, T0, 0, 64'h2000_0000_0000, 0);
    // R3: concatenated start tables
    run_walk("R3 concat", 0, 24, 48, 1, 64'h80000, 0, (64'd1 << 39) | ipa4k(0, 2, 1, 1, 64'h10), 0);
    // R8 R3: address size fault, base bits above eps masked off
    run_walk("R8 asize", 0, 16, 40, 0, T0 | (64'd1 << 44), 0, ipa4k(1, 2, 3, 10, 64'h4), 0);
    // R3 R9: 64K and 16K granules
    run_walk("R3 64k", 2, 22, 48, 2, 64'h200000, 0, (64'd3 << 29) | (64'd5 << 16) | 64'h1234, 0);
    run_walk("R3 16k", 1, 28, 48, 1, 64'h300000, 0, (64'd2 << 25) | (64'd3 << 14) | 64'h155, 0);
    run_walk("R7 16k write", 1, 28, 48, 1, 64'h300000, 0, (64'd2 << 25) | (64'd3 << 14) | 64'h155, 1);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule